// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences the low-power modes of a small microcontroller core. A single sleep strobe from the core puts it into one of two modes. If the idle-enable control bit is clear, it enters full sleep: both clocks are gated and the fast oscillators are shut off. If the bit is set, it enters idle: only the CPU clock is stopped, and the peripherals keep running from the selected source. The block drives separate gate enables for the CPU clock and the peripheral clock. It also drives an enable for each oscillator, one status bit per clock source, and a flag that is high only while the primary oscillator is feeding the device.

Leaving a low-power mode takes an interrupt, a watchdog time-out or a system reset request. A wake from sleep keeps the device unclocked until the selected source reports ready. The exception is when a fallback internal clock is permitted: the device then runs from the internal oscillator in the meantime. A wake from idle holds the CPU clock off for a fixed start-up delay and then resumes on the same source. A reset request wins over every other source and returns to run at once. The idle-enable and clock-select bits are inputs that the block only reads, so every wake resumes on the currently selected source.

States:
- ST_RUN
- ST_IDLE
- ST_IDLE_DLY (start-up delay after an idle wake)
- ST_SLEEP
- ST_WAKE_WAIT (gated, waiting for the selected source)
- ST_WAKE_FB (running on the internal fallback while the selected source starts)

Transitions:
- RUN to IDLE or SLEEP on the strobe.
- IDLE to IDLE_DLY on an interrupt or time-out.
- IDLE_DLY to RUN after the delay.
- SLEEP to WAKE_WAIT or WAKE_FB on an interrupt or time-out.
- WAKE_WAIT and WAKE_FB to RUN when the selected source is ready.
- Any state to RUN on a reset request.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_n is released, the block is in run, with cpu_clk_en=1 and per_clk_en=1. clk_sel encodes 00 primary, 01 secondary and 1x internal. src_stat bit0 is primary, bit1 secondary and bit2 internal. In run, src_stat is the one-hot bit of the selected source.
- R2: A sleep_req in run with idle_en=0 leads, from the next cycle, to cpu_clk_en=0, per_clk_en=0, src_stat=000, pri_osc_en=0 and int_osc_en=0.
- R3: A sleep_req in run with idle_en=1 leads, from the next cycle, to cpu_clk_en=0 and per_clk_en=1. src_stat stays at the selected source, and that source's oscillator enable stays 1.
- R4: lf_osc_en follows wdt_sel in every mode. In sleep, sec_osc_en equals sosc_en.
- R5: In sleep or idle, only wake_irq, wake_wdt or wake_rst change the mode. sleep_req, idle_en and ready inputs have no effect.
- R6: After an interrupt or time-out wake from sleep without fallback, both clock enables stay 0 while the selected source's ready input is 0. They become 1 in the cycle after that input is seen at 1.
- R7: With fallback_en=1 and a non-internal source selected, a wake from sleep gives, from the next cycle, cpu_clk_en=per_clk_en=1, int_osc_en=1 and src_stat=100. When the selected source becomes ready, the block runs on it.
- R8: pri_running is 1 exactly in run or idle with the primary source selected. It is 0 in sleep, while waiting and on the fallback clock.
- R9: After an interrupt or time-out wake from idle, per_clk_en stays 1 and cpu_clk_en stays 0 for WAKE_DLY cycles, then becomes 1 on the same source.
- R10: A watchdog time-out wake from sleep or idle returns to run on the source given by the current clk_sel, with no reset behaviour.
- R11: wake_rst returns the block to run at the next edge from any state, with no delay and regardless of readiness. It takes priority over all other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction strobe |
| idle_en | input | 1 | 1: strobe enters idle, 0: sleep |
| clk_sel | input | 2 | Clock source select (00 pri, 01 sec, 1x int) |
| wdt_sel | input | 1 | Watchdog enabled, keeps low-frequency oscillator on |
| sosc_en | input | 1 | Secondary oscillator kept running |
| fallback_en | input | 1 | Permit internal-clock operation during start-up |
| wake_irq | input | 1 | Interrupt wake event |
| wake_wdt | input | 1 | Watchdog time-out wake event |
| wake_rst | input | 1 | System reset request |
| pri_rdy | input | 1 | Primary oscillator ready |
| sec_rdy | input | 1 | Secondary oscillator ready |
| int_rdy | input | 1 | Internal oscillator ready |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| src_stat | output | 3 | Active clock source status bits |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| int_osc_en | output | 1 | Internal fast oscillator enable |
| lf_osc_en | output | 1 | Low-frequency internal oscillator enable |
| pri_running | output | 1 | Primary oscillator is clocking the device |

## Verification
The strobe is tried with idle-enable both clear and set. This tells full gating apart from CPU-only gating. Each wake is tried with each of the three source selects and with readiness arriving late or already present. This separates waiting from immediate resumption and shows which ready input is consulted. Fallback is tried against a primary select, wake_rst is tried alone and together with an interrupt, and a stray strobe and ready pulse are applied during sleep. Together these distinguish the reset priority and the ignored inputs from the regular wake paths.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_IDLE_DLY,
        ST_SLEEP,
        ST_WAKE_WAIT,
        ST_WAKE_FB
    } pmc_state_e;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } pmc_src_e;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;

    function automatic pmc_src_e sel_to_src(input logic [SEL_W-1:0] sel);
        if (sel[1])
            return SRC_INT;
        else if (sel[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/pmc_src_decode.sv
module pmc_src_decode
    import pmc_pkg::*;
(
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic [NUM_SRC-1:0] rdy_vec,
    output pmc_src_e           src,
    output logic [NUM_SRC-1:0] src_onehot,
    output logic               sel_rdy
);

    assign src = sel_to_src(clk_sel);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_onehot
        assign src_onehot[g] = (int'(src) == g);
    end

    assign sel_rdy = |(rdy_vec & src_onehot);

endmodule

// File: rtl/pmc_wake_arb.sv
module pmc_wake_arb (
    input  logic wake_irq,
    input  logic wake_wdt,
    input  logic wake_rst,
    output logic wake_hard,
    output logic wake_soft
);

    // Reset request wins; interrupt and time-out share the regular path.
    assign wake_hard = wake_rst;
    assign wake_soft = (wake_irq | wake_wdt) & ~wake_rst;

endmodule

// File: rtl/pmc_dly_cnt.sv
module pmc_dly_cnt #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int            CW   = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (run && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_DLY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                idle_en,
    input  logic [1:0]          clk_sel,
    input  logic                wdt_sel,
    input  logic                sosc_en,
    input  logic                fallback_en,
    input  logic                wake_irq,
    input  logic                wake_wdt,
    input  logic                wake_rst,
    input  logic                pri_rdy,
    input  logic                sec_rdy,
    input  logic                int_rdy,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic [2:0]          src_stat,
    output logic                pri_osc_en,
    output logic                sec_osc_en,
    output logic                int_osc_en,
    output logic                lf_osc_en,
    output logic                pri_running
);

    pmc_state_e          state, nxt;
    pmc_src_e            src;
    logic [NUM_SRC-1:0]  src_onehot;
    logic                sel_rdy;
    logic                wake_hard, wake_soft;
    logic                dly_start, dly_done;

    pmc_src_decode u_dec (
        .clk_sel    (clk_sel),
        .rdy_vec    ({int_rdy, sec_rdy, pri_rdy}),
        .src        (src),
        .src_onehot (src_onehot),
        .sel_rdy    (sel_rdy)
    );

    pmc_wake_arb u_arb (
        .wake_irq  (wake_irq),
        .wake_wdt  (wake_wdt),
        .wake_rst  (wake_rst),
        .wake_hard (wake_hard),
        .wake_soft (wake_soft)
    );

    pmc_dly_cnt #(.DLY(WAKE_DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dly_start),
        .run   (state == ST_IDLE_DLY),
        .done  (dly_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (wake_hard) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:       if (sleep_req) nxt = idle_en ? ST_IDLE : ST_SLEEP;
                ST_IDLE:      if (wake_soft) nxt = ST_IDLE_DLY;
                ST_IDLE_DLY:  if (dly_done)  nxt = ST_RUN;
                ST_SLEEP:     if (wake_soft)
                                  nxt = (fallback_en && src != SRC_INT) ? ST_WAKE_FB
                                                                        : ST_WAKE_WAIT;
                ST_WAKE_WAIT: if (sel_rdy)   nxt = ST_RUN;
                ST_WAKE_FB:   if (sel_rdy)   nxt = ST_RUN;
                default:                     nxt = ST_RUN;
            endcase
        end
    end

    assign dly_start = (state == ST_IDLE) && (nxt == ST_IDLE_DLY);

    // Output decode
    always_comb begin
        cpu_clk_en  = 1'b0;
        per_clk_en  = 1'b0;
        src_stat    = '0;
        pri_osc_en  = src_onehot[SRC_PRI];
        sec_osc_en  = sosc_en | src_onehot[SRC_SEC];
        int_osc_en  = src_onehot[SRC_INT];
        lf_osc_en   = wdt_sel;
        pri_running = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en  = 1'b1;
                per_clk_en  = 1'b1;
                src_stat    = src_onehot;
                pri_running = src_onehot[SRC_PRI];
            end
            ST_IDLE, ST_IDLE_DLY: begin
                per_clk_en  = 1'b1;
                src_stat    = src_onehot;
                pri_running = src_onehot[SRC_PRI];
            end
            ST_SLEEP: begin
                pri_osc_en  = 1'b0;
                sec_osc_en  = sosc_en;
                int_osc_en  = 1'b0;
            end
            ST_WAKE_WAIT: begin
                // gated; selected oscillator starting
            end
            ST_WAKE_FB: begin
                cpu_clk_en  = 1'b1;
                per_clk_en  = 1'b1;
                int_osc_en  = 1'b1;
                src_stat    = 3'b100;
            end
            default: begin
                cpu_clk_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       idle_en,
    input logic       sosc_en,
    input logic       wake_irq,
    input logic       wake_wdt,
    input logic       wake_rst,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic [2:0] src_stat,
    input logic       pri_osc_en,
    input logic       sec_osc_en,
    input logic       pri_running,
    input pmc_state_e state
);

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !idle_en && !wake_rst)
        |=> (!cpu_clk_en && !per_clk_en && src_stat == 3'b000)); // R2

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && idle_en && !wake_rst)
        |=> (!cpu_clk_en && per_clk_en)); // R3

    AST_SLEEP_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> (sec_osc_en == sosc_en && !pri_osc_en)); // R4

    AST_NO_STRAY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wake_irq && !wake_wdt && !wake_rst)
        |=> (!per_clk_en && !cpu_clk_en)); // R5

    AST_PRI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pri_running |-> (per_clk_en && src_stat == 3'b001)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (wake_irq || wake_wdt) && !wake_rst)
        |=> (!cpu_clk_en && per_clk_en)); // R9

    AST_RST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> (cpu_clk_en && per_clk_en)); // R11

endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .idle_en     (idle_en),
    .sosc_en     (sosc_en),
    .wake_irq    (wake_irq),
    .wake_wdt    (wake_wdt),
    .wake_rst    (wake_rst),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .src_stat    (src_stat),
    .pri_osc_en  (pri_osc_en),
    .sec_osc_en  (sec_osc_en),
    .pri_running (pri_running),
    .state       (state)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

    localparam int DLY = 4;
    localparam int M_RUN = 0, M_IDLE = 1, M_IDLEW = 2, M_SLEEP = 3, M_WAIT = 4, M_FB = 5;

    logic clk = 1'b0;
    logic rst_n, sleep_req, idle_en, wdt_sel, sosc_en, fallback_en;
    logic [1:0] clk_sel;
    logic wake_irq, wake_wdt, wake_rst, pri_rdy, sec_rdy, int_rdy;
    logic cpu_clk_en, per_clk_en, pri_osc_en, sec_osc_en, int_osc_en, lf_osc_en, pri_running;
    logic [2:0] src_stat;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int m_st = M_RUN;
    int m_left = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_DLY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
        .clk_sel(clk_sel), .wdt_sel(wdt_sel), .sosc_en(sosc_en),
        .fallback_en(fallback_en), .wake_irq(wake_irq), .wake_wdt(wake_wdt),
        .wake_rst(wake_rst), .pri_rdy(pri_rdy), .sec_rdy(sec_rdy), .int_rdy(int_rdy),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .src_stat(src_stat),
        .pri_osc_en(pri_osc_en), .sec_osc_en(sec_osc_en), .int_osc_en(int_osc_en),
        .lf_osc_en(lf_osc_en), .pri_running(pri_running)
    );

    function automatic int sel_idx();
        if (clk_sel[1]) return 2;
        if (clk_sel[0]) return 1;
        return 0;
    endfunction

    function automatic logic sel_ready();
        case (sel_idx())
            0: return pri_rdy;
            1: return sec_rdy;
            default: return int_rdy;
        endcase
    endfunction

    // Reference: packed {cpu, per, stat[2:0], pri, sec, int, lf, prun}
    function automatic logic [9:0] model_out();
        int s = sel_idx();
        logic [2:0] oh = 3'b001 << s;
        logic cpu = 0, per = 0, pr = 0, sc = 0, it = 0, run_pri = 0;
        logic [2:0] st = 3'b000;
        sc = sosc_en || s == 1;
        pr = (s == 0);
        it = (s == 2);
        if (m_st == M_RUN) begin cpu = 1; per = 1; st = oh; run_pri = (s == 0); end
        else if (m_st == M_IDLE || m_st == M_IDLEW) begin per = 1; st = oh; run_pri = (s == 0); end
        else if (m_st == M_SLEEP) begin pr = 0; it = 0; sc = sosc_en; end
        else if (m_st == M_FB) begin cpu = 1; per = 1; it = 1; st = 3'b100; end
        return {cpu, per, st, pr, sc, it, wdt_sel, run_pri};
    endfunction

    function automatic string state_tag();
        case (m_st)
            M_RUN:   return "R1";
            M_IDLE:  return "R3";
            M_IDLEW: return "R9";
            M_SLEEP: return "R2";
            M_WAIT:  return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= M_RUN;
            m_left <= 0;
        end else if (wake_rst) begin
            m_st <= M_RUN;
        end else begin
            case (m_st)
                M_RUN:   if (sleep_req) m_st <= idle_en ? M_IDLE : M_SLEEP;
                M_IDLE:  if (wake_irq || wake_wdt) begin m_st <= M_IDLEW; m_left <= DLY; end
                M_IDLEW: begin
                    if (m_left == 1) m_st <= M_RUN;
                    m_left <= m_left - 1;
                end
                M_SLEEP: if (wake_irq || wake_wdt)
                             m_st <= (fallback_en && sel_idx() != 2) ? M_FB : M_WAIT;
                default: if (sel_ready()) m_st <= M_RUN;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1)
            chk(state_tag(),
                {22'd0, cpu_clk_en, per_clk_en, src_stat, pri_osc_en, sec_osc_en,
                 int_osc_en, lf_osc_en, pri_running},
                {22'd0, model_out()});
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    initial begin
        rst_n = 0; sleep_req = 0; idle_en = 0; clk_sel = 2'b00; wdt_sel = 0;
        sosc_en = 0; fallback_en = 0; wake_irq = 0; wake_wdt = 0; wake_rst = 0;
        pri_rdy = 1; sec_rdy = 0; int_rdy = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 cpu", cpu_clk_en, 1); chk("R1 per", per_clk_en, 1); chk("R1 stat", src_stat, 3'b001);

        // Full sleep, primary selected
        wdt_sel = 1; sosc_en = 1; pri_rdy = 0; sleep_req = 1;
        tick(); sleep_req = 0;
        chk("R2 cpu", cpu_clk_en, 0); chk("R2 per", per_clk_en, 0);
        chk("R2 stat", src_stat, 0); chk("R2 pri_osc", pri_osc_en, 0);
        chk("R4 lf", lf_osc_en, 1); chk("R4 sec", sec_osc_en, 1); chk("R8 prun", pri_running, 0);
        sleep_req = 1; pri_rdy = 1; idle_en = 1;
        tick(); sleep_req = 0; pri_rdy = 0; idle_en = 0;
        tick();
        chk("R5 per", per_clk_en, 0); chk("R5 cpu", cpu_clk_en, 0);
        wake_irq = 1;
        tick(); wake_irq = 0;
        repeat (3) tick();
        chk("R6 cpu held", cpu_clk_en, 0); chk("R6 pri_osc", pri_osc_en, 1);
        pri_rdy = 1;
        tick();
        chk("R6 cpu", cpu_clk_en, 1); chk("R6 stat", src_stat, 3'b001); chk("R8 prun", pri_running, 1);

        // Idle on internal source, watchdog wake
        clk_sel = 2'b10; int_rdy = 1; idle_en = 1;
        tick(); sleep_req = 1;
        tick(); sleep_req = 0;
        chk("R3 cpu", cpu_clk_en, 0); chk("R3 per", per_clk_en, 1);
        chk("R3 stat", src_stat, 3'b100); chk("R3 int_osc", int_osc_en, 1);
        wake_wdt = 1;
        tick(); wake_wdt = 0;
        chk("R9 cpu d0", cpu_clk_en, 0);
        repeat (DLY - 1) tick();
        chk("R9 cpu dN", cpu_clk_en, 0); chk("R9 per", per_clk_en, 1);
        tick();
        chk("R9 cpu", cpu_clk_en, 1); chk("R10 stat", src_stat, 3'b100);

        // Fallback while primary starts
        clk_sel = 2'b00; pri_rdy = 0; idle_en = 0; fallback_en = 1;
        tick(); sleep_req = 1;
        tick(); sleep_req = 0; wake_irq = 1;
        tick(); wake_irq = 0;
        chk("R7 cpu", cpu_clk_en, 1); chk("R7 stat", src_stat, 3'b100);
        chk("R7 int_osc", int_osc_en, 1); chk("R7 pri_osc", pri_osc_en, 1); chk("R8 prun fb", pri_running, 0);
        repeat (2) tick();
        pri_rdy = 1;
        tick();
        chk("R7 stat", src_stat, 3'b001); chk("R8 prun", pri_running, 1);

        // Secondary source, watchdog wake from sleep
        fallback_en = 0; clk_sel = 2'b01; sec_rdy = 1;
        tick(); sleep_req = 1;
        tick(); sleep_req = 0;
        chk("R4 sec on", sec_osc_en, 1);
        sosc_en = 0;
        tick();
        chk("R4 sec off", sec_osc_en, 0);
        wake_wdt = 1;
        tick(); wake_wdt = 0;
        chk("R6 cpu wait", cpu_clk_en, 0);
        tick();
        chk("R10 cpu", cpu_clk_en, 1); chk("R10 stat", src_stat, 3'b010);

        // Reset request wakes
        idle_en = 1; sleep_req = 1;
        tick(); sleep_req = 0; wake_rst = 1;
        tick(); wake_rst = 0;
        chk("R11 idle cpu", cpu_clk_en, 1); chk("R11 idle per", per_clk_en, 1);
        idle_en = 0; clk_sel = 2'b00; pri_rdy = 0; sleep_req = 1;
        tick(); sleep_req = 0; wake_rst = 1; wake_irq = 1;
        tick(); wake_rst = 0; wake_irq = 0;
        chk("R11 sleep cpu", cpu_clk_en, 1); chk("R11 stat", src_stat, 3'b001);

        // Idle on primary keeps the primary flag
        pri_rdy = 1; idle_en = 1; sleep_req = 1;
        tick(); sleep_req = 0;
        chk("R8 idle prun", pri_running, 1); chk("R3 idle cpu", cpu_clk_en, 0);
        wake_irq = 1;
        tick(); wake_irq = 0;
        repeat (DLY) tick();
        chk("R9 resume", cpu_clk_en, 1);

        tick();
        summary();
        $finish;
    end

endmodule